// File: doc/BRIEF.md
# Write-Through Invalidate Cache Line Controller

This block keeps a direct-mapped, write-through cache coherent on a shared snooping bus. Every line carries one word, a tag and a single valid bit, so a line is either Valid or Invalid; any line not present counts as Invalid. Processor reads that hit are answered from the line store without touching the bus. Reads that miss fetch the word with a bus read and install it. Every processor write is sent to memory with a bus write, so memory always holds the current value. A write updates the local word only when the line is already present, and never allocates.

The bus side asks an external arbiter for the bus, waits for a grant, then waits for the completion strobe. The processor is held off through a ready strobe until that completion. A snoop port watches the transactions of the other caches. A snooped bus write whose address matches a Valid line invalidates that line. The tag store has one lookup port, and a snoop in a given cycle takes it ahead of the processor.

Top module: `wti_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is low and `bus_req` is low. The first read of any address is a miss.
- R2: A read to an Invalid line raises `bus_req` with `bus_cmd`=0 (read) and the request address. When `bus_done` is seen, `cpu_rdata` returns `bus_rdata` with `cpu_hit`=0, and the line becomes Valid.
- R3: A read to a Valid line with a matching tag is answered one cycle after acceptance with `cpu_hit`=1 and the stored word. No bus request is raised.
- R4: Every processor write raises `bus_req` with `bus_cmd`=1 (write), the request address and the write data, whether the line is Valid or Invalid.
- R5: A write whose line is Valid with a matching tag also replaces the stored word, so a later read hit returns the new value.
- R6: A write to an Invalid or non-matching line leaves the line unchanged (no allocation). A later read of that address misses.
- R7: A snooped transaction with `snp_wr`=1 whose address matches a Valid line makes that line Invalid.
- R8: A snooped read (`snp_wr`=0), or a snooped write with the same index but a different tag, leaves the line Valid.
- R9: In a cycle where `snp_valid` is high, no processor request is accepted. `cpu_ready` and `bus_req` stay low until the snoop cycle has passed.
- R10: Once a bus request is raised, `bus_req`, `bus_cmd` and `bus_addr` hold until `bus_done`. `cpu_ready` pulses for exactly one cycle, in the cycle after `bus_done`.
- R11: If a snooped write to the same address arrives in the cycle a read miss completes, the fill is dropped and the line stays Invalid. The read still returns the bus data.
- R12: The address is a word address. The index is its low log2(LINES) bits and the tag is the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_hit | output | 1 | Read was served locally (valid with `cpu_ready`) |
| cpu_rdata | output | DATA_W | Read data (valid with `cpu_ready`) |
| bus_req | output | 1 | Bus request, held until `bus_done` |
| bus_cmd | output | 1 | 0 = bus read, 1 = bus write |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_done | input | 1 | Transaction complete strobe |
| bus_rdata | input | DATA_W | Bus read data, valid with `bus_done` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_wr | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped address |

## Verification
Suppose a request is sampled on clock edge k. A read hit gives `cpu_ready` after edge k. A miss or a write raises `bus_req` after edge k, takes `bus_gnt` on some later edge, and gives `cpu_ready` after the edge on which `bus_done` is sampled. The bench drives every input on the falling edge and reads every output on the next falling edge. Its bus responder places grant and completion on exact falling edges, so each expected result is compared in the one half-cycle where it must appear. Each snoop is applied for exactly one cycle before the following access, or in the same cycle as a completion strobe, so its effect shows up in the hit or miss of the next read.

// File: rtl/wti_pkg.sv
package wti_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } wti_state_e;

    localparam logic CMD_READ  = 1'b0;
    localparam logic CMD_WRITE = 1'b1;

endpackage

// File: rtl/wti_line_store.sv
module wti_line_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [LINES-1:0]             vld;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] dat;
    } store_t;

    store_t st_d, st_q;

    assign lk_valid = st_q.vld[lk_idx];
    assign lk_tag   = st_q.tag[lk_idx];
    assign lk_data  = st_q.dat[lk_idx];

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.vld[fill_idx] = 1'b1;
            st_d.tag[fill_idx] = fill_tag;
            st_d.dat[fill_idx] = fill_data;
        end
        if (upd_en && st_q.vld[upd_idx] && (st_q.tag[upd_idx] == upd_tag)) begin
            st_d.dat[upd_idx] = upd_data;
        end
        // invalidation is applied last so it wins over any update of the same line
        if (inv_en) begin
            st_d.vld[inv_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wti_snoop_unit.sv
module wti_snoop_unit #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              snp_valid,
    input  logic              snp_wr,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              lk_valid,
    input  logic [ADDR_W-IDX_W-1:0] lk_tag,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [ADDR_W-IDX_W-1:0] fill_tag,
    output logic [IDX_W-1:0]  lk_idx,
    output logic              port_free,
    output logic              inv_en,
    output logic [IDX_W-1:0]  inv_idx
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    logic             hit_stored;
    logic             hit_filling;

    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    // the snoop owns the single lookup port whenever it is present
    assign lk_idx    = snp_valid ? s_idx : cpu_addr[IDX_W-1:0];
    assign port_free = !snp_valid;

    assign hit_stored  = lk_valid && (lk_tag == s_tag);
    assign hit_filling = fill_en && (fill_idx == s_idx) && (fill_tag == s_tag);

    assign inv_en  = snp_valid && snp_wr && (hit_stored || hit_filling);
    assign inv_idx = s_idx;

endmodule

// File: rtl/wti_ctrl_fsm.sv
module wti_ctrl_fsm
    import wti_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              port_free,
    input  logic              lk_valid,
    input  logic [ADDR_W-IDX_W-1:0] lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              bus_req,
    output logic              bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              fill_en,
    output logic              upd_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ADDR_W-IDX_W-1:0] wr_tag,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        wti_state_e        st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rdy;
        logic              hit;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  accept;
    logic  tag_match;
    logic  finish;

    assign accept    = (c_q.st == ST_IDLE) && cpu_req && port_free && !c_q.rdy;
    assign tag_match = lk_valid && (lk_tag == cpu_addr[ADDR_W-1:IDX_W]);
    assign finish    = (c_q.st == ST_XFER) && bus_done;

    always_comb begin
        c_d     = c_q;
        c_d.rdy = 1'b0;
        c_d.hit = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (!cpu_we && tag_match) begin
                        c_d.rdy   = 1'b1;
                        c_d.hit   = 1'b1;
                        c_d.rdata = lk_data;
                    end else begin
                        c_d.st    = ST_REQ;
                        c_d.we    = cpu_we;
                        c_d.addr  = cpu_addr;
                        c_d.wdata = cpu_wdata;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt) c_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (bus_done) begin
                    c_d.st    = ST_IDLE;
                    c_d.rdy   = 1'b1;
                    c_d.rdata = c_q.we ? c_q.wdata : bus_rdata;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cpu_ready = c_q.rdy;
    assign cpu_hit   = c_q.hit;
    assign cpu_rdata = c_q.rdata;

    assign bus_req   = (c_q.st != ST_IDLE);
    assign bus_cmd   = c_q.we ? CMD_WRITE : CMD_READ;
    assign bus_addr  = c_q.addr;
    assign bus_wdata = c_q.wdata;

    assign fill_en = finish && !c_q.we;
    assign upd_en  = finish && c_q.we;
    assign wr_idx  = c_q.addr[IDX_W-1:0];
    assign wr_tag  = c_q.addr[ADDR_W-1:IDX_W];
    assign wr_data = c_q.we ? c_q.wdata : bus_rdata;

endmodule

// File: rtl/wti_cache_ctrl.sv
module wti_cache_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic              bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_wr,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              port_free;
    logic              inv_en;
    logic [IDX_W-1:0]  inv_idx;
    logic              fill_en;
    logic              upd_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    wti_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_wr    (snp_wr),
        .snp_addr  (snp_addr),
        .cpu_addr  (cpu_addr),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .fill_en   (fill_en),
        .fill_idx  (wr_idx),
        .fill_tag  (wr_tag),
        .lk_idx    (lk_idx),
        .port_free (port_free),
        .inv_en    (inv_en),
        .inv_idx   (inv_idx)
    );

    wti_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .lk_data   (lk_data),
        .fill_en   (fill_en),
        .fill_idx  (wr_idx),
        .fill_tag  (wr_tag),
        .fill_data (wr_data),
        .upd_en    (upd_en),
        .upd_idx   (wr_idx),
        .upd_tag   (wr_tag),
        .upd_data  (wr_data),
        .inv_en    (inv_en),
        .inv_idx   (inv_idx)
    );

    wti_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_hit   (cpu_hit),
        .cpu_rdata (cpu_rdata),
        .port_free (port_free),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .lk_data   (lk_data),
        .bus_req   (bus_req),
        .bus_cmd   (bus_cmd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_gnt   (bus_gnt),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .fill_en   (fill_en),
        .upd_en    (upd_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data)
    );

endmodule

// File: rtl/wti_checker.sv
module wti_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_hit,
    input logic              bus_req,
    input logic              bus_done,
    input logic              bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid
);

    // R10
    bus_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> bus_req);

    // R10
    bus_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req) && !$past(bus_done)) |-> ($stable(bus_cmd) && $stable(bus_addr)));

    // R10
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_hit) |-> $past(bus_done));

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R3
    hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_hit) |-> !$past(bus_req));

    // R9
    snoop_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !bus_req && !cpu_ready) |=> (!bus_req && !cpu_ready));

endmodule

bind wti_cache_ctrl wti_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_hit   (cpu_hit),
    .bus_req   (bus_req),
    .bus_done  (bus_done),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .snp_valid (snp_valid)
);

// File: tb/sim_wti_cache_ctrl.sv
module sim_wti_cache_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready, cpu_hit;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_gnt = 1'b0, bus_done = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0, snp_wr = 1'b0;
    logic [AW-1:0] snp_addr = '0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    wti_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(16)) u0 (.*);

    typedef struct {
        bit            hit;
        bit            is_wr;
        logic [DW-1:0] data;
        logic [AW-1:0] addr;
        int            rq;
    } exp_t;

    exp_t          sb_q[$];
    logic [DW-1:0] mem [int];

    bit            seen_bus = 0;
    logic          seen_cmd;
    logic [AW-1:0] seen_addr;
    logic [DW-1:0] seen_wdata;

    function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {16'hD00D, a};
    endfunction

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per completion strobe
    always @(negedge clk) begin
        if (rst_n && bus_req && !seen_bus) begin
            seen_bus   = 1;
            seen_cmd   = bus_cmd;
            seen_addr  = bus_addr;
            seen_wdata = bus_wdata;
        end
        if (rst_n && cpu_ready) begin
            if (sb_q.size() == 0) begin
                check(0, 10, "unexpected cpu_ready", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(cpu_hit == e.hit, e.rq, "hit", cpu_hit, e.hit);
                if (!e.is_wr) check(cpu_rdata == e.data, e.rq, "read data", cpu_rdata, e.data);
                if (e.hit) begin
                    check(!seen_bus, e.rq, "bus used on hit", seen_bus, 0);
                end else begin
                    check(seen_bus && seen_cmd == e.is_wr && seen_addr == e.addr &&
                          (!e.is_wr || seen_wdata == e.data), e.rq, "bus transaction",
                          {seen_cmd, seen_addr}, {e.is_wr, e.addr});
                end
            end
            seen_bus = 0;
        end
    end

    task automatic snoop(input bit wr, input logic [AW-1:0] a);
        @(negedge clk);
        snp_valid = 1; snp_wr = wr; snp_addr = a;
        @(negedge clk);
        snp_valid = 0; snp_wr = 0;
    endtask

    // driver: one processor access plus the bus responder for it
    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input bit exp_hit, input int gdly, input int snp_hold,
                          input bit snp_at_done, input int rq);
        exp_t e;
        int   cnt = 0;
        bit   granted = 0, done_sent = 0, bus_seen = 0, hold_ok = 1;
        e.hit = exp_hit; e.is_wr = we; e.addr = a; e.rq = rq;
        e.data = we ? wd : mem_rd(a);
        sb_q.push_back(e);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (snp_hold > 0) begin
            snp_valid = 1; snp_wr = 0; snp_addr = 16'h0777;
            for (int i = 0; i < snp_hold; i++) begin
                @(negedge clk);
                // R9: request held off while the snoop owns the lookup port
                check(!cpu_ready && !bus_req, 9, "accepted during snoop", {cpu_ready, bus_req}, 0);
            end
            snp_valid = 0;
        end
        while (!cpu_ready) begin
            bus_gnt = 0; bus_done = 0;
            if (snp_at_done) begin snp_valid = 0; snp_wr = 0; end
            if (bus_seen && !bus_req) hold_ok = 0;
            if (bus_req) bus_seen = 1;
            if (bus_req && !granted) begin
                if (cnt == gdly) begin bus_gnt = 1; granted = 1; end
                else cnt++;
            end else if (granted && !done_sent) begin
                bus_done = 1; bus_rdata = mem_rd(a);
                if (we) mem[int'(a)] = wd;
                done_sent = 1;
                if (snp_at_done) begin snp_valid = 1; snp_wr = 1; snp_addr = a; end
            end
            @(negedge clk);
        end
        bus_gnt = 0; bus_done = 0; cpu_req = 0;
        if (snp_at_done) begin snp_valid = 0; snp_wr = 0; end
        // R10: request held from raise to completion
        if (bus_seen) check(hold_ok, 10, "bus_req dropped early", hold_ok, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!cpu_ready && !bus_req, 1, "reset outputs", {cpu_ready, bus_req}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!cpu_ready && !bus_req, 1, "idle after reset", {cpu_ready, bus_req}, 0);
        // R1 R2 R12: first read misses and fills index 2
        access(0, 16'h0012, 0, 0, 0, 0, 0, 2);
        // R3: read hit served locally
        access(0, 16'h0012, 0, 1, 0, 0, 0, 3);
        // R4 R5: write hit goes on the bus and updates the line
        access(1, 16'h0012, 32'hAAAA_0001, 0, 1, 0, 0, 4);
        access(0, 16'h0012, 0, 1, 0, 0, 0, 5);
        // R4 R6: write miss, no allocation; later read misses and sees memory
        access(1, 16'h0123, 32'h1234_5678, 0, 0, 0, 0, 6);
        access(0, 16'h0123, 0, 0, 0, 0, 0, 6);
        access(0, 16'h0123, 0, 1, 0, 0, 0, 3);
        // R7: snooped write to a valid line invalidates it
        snoop(1, 16'h0123);
        access(0, 16'h0123, 0, 0, 0, 0, 0, 7);
        // R8: snooped read and different-tag snooped write leave index 2 valid
        snoop(0, 16'h0012);
        access(0, 16'h0012, 0, 1, 0, 0, 0, 8);
        snoop(1, 16'h0F12);
        access(0, 16'h0012, 0, 1, 0, 0, 0, 8);
        // R9: snoop for three cycles defers acceptance
        access(0, 16'h0012, 0, 1, 0, 3, 0, 9);
        // R10: long grant delay on a miss
        access(0, 16'h0234, 0, 0, 5, 0, 0, 10);
        access(0, 16'h0234, 0, 1, 0, 0, 0, 10);
        // R11: snooped write in the fill cycle drops the fill
        access(0, 16'h0045, 0, 0, 2, 0, 1, 11);
        access(0, 16'h0045, 0, 0, 0, 0, 0, 11);
        // R12: same index, other tag evicts and misses
        access(0, 16'h1045, 0, 0, 0, 0, 0, 12);
        access(0, 16'h0045, 0, 0, 0, 0, 0, 12);
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, 10, "missing completions", sb_q.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule